// File: doc/BRIEF.md
# Serial Flash Write Guard

This block is the protection core of a serial flash device. An SPI front end delivers one event per instruction when chip select is released: the opcode, how many serial clocks were counted, the address and the status data byte. The block keeps the status word and decides whether each write-type instruction may start. The inputs it weighs are the write latch, the block-protect field, the write-protect pin, the deep power-down state, a one-time-programmable lock and a power-up wait timer. Accepted instructions go to an array engine as a start pulse with a kind code and an address. The engine reports completion with a one-cycle done pulse. The busy flag stays up until that pulse arrives.

Each instruction event produces at most one registered verdict pulse. The verdict is accept or reject, and an ignored instruction produces neither. The status word, the engine start and the verdict all change on the clock edge that samples the event. Completion takes effect on the edge that samples `opDone`.

Top module: `flash_guard`

## Requirements
- R1: Status bit 0 (busy) rises on the edge that accepts a status write, program or erase, together with a one-cycle `opStart` whose `opKind` is 0 status write, 1 page program, 2 sector erase, 3 block erase or 4 chip erase. It falls on the edge that samples `opDone`.
- R2: Status bit 1 (write latch) is set only by opcode 0x06. Status write 0x01, page program 0x02, sector erase 0x20, block erase 0xD8 and chip erase 0xC7 are rejected while it is 0.
- R3: The write latch clears on write-disable 0x04, on completion of any started operation, and when a write-type instruction is refused for protection.
- R4: A write-type instruction whose clock count is not a multiple of eight is rejected and leaves the write latch unchanged.
- R5: While status bit 7 (SRP) is 1 and `wpN` is low, a status write is rejected and the write latch clears.
- R6: The block-protect field (status bits 4:2) guards the top of the array: 0 guards nothing, 1 to 6 guard the top 1/64, 1/32, 1/16, 1/8, 1/4 and 1/2, and 7 guards everything. A program or erase that touches any guarded byte is rejected. For an erase, the whole aligned sector or block counts. A chip erase is rejected for any nonzero field.
- R7: After opcode 0xB9 the block is in deep power-down (`deepPd` high). Every instruction except 0xAB is ignored and changes nothing. 0xAB leaves the mode and is accepted.
- R8: With `otpMode` high, status bit 7 shows the lock. An accepted status write ignores its data and sets the lock at completion. The lock never clears. While it is set, program, erase and status write are rejected in that mode.
- R9: Until `PUW_CYCLES` cycles after reset (`puwDone` low), opcode 0x06 and all write-type instructions are rejected.
- R10: While busy, every instruction is ignored with no verdict. This includes one sampled on the same edge as `opDone`.
- R11: A completed status write outside OTP mode copies data bits 7 and 4:2 into SRP and the protect field. Status bits 6:5 always read 0.
- R12: After reset the status word is 0x00, and `deepPd`, `puwDone` and the verdict pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| cmdValid | input | 1 | One-cycle instruction event |
| cmdOp | input | 8 | Opcode |
| cmdBits | input | CNT_W | Serial clocks counted while selected |
| cmdAddr | input | ADDR_W | Byte address of program or erase |
| cmdData | input | 8 | Status write data byte |
| wpN | input | 1 | Write-protect pin, active low |
| otpMode | input | 1 | OTP sector mode selected |
| opDone | input | 1 | Engine completion pulse |
| opStart | output | 1 | Engine start pulse |
| opKind | output | 3 | Operation kind code |
| opAddr | output | ADDR_W | Operation address |
| statusReg | output | 8 | Status word |
| cmdAccept | output | 1 | Instruction accepted pulse |
| cmdReject | output | 1 | Instruction rejected pulse |
| deepPd | output | 1 | Deep power-down active |
| puwDone | output | 1 | Power-up wait expired |

## Verification
Engine completion and a new instruction event can land on the same clock edge. The busy flag is then still set, so the event must be ignored, while the completion still clears both busy and the write latch. The bench arranges this by counting the engine latency after a program is started and issuing a write-enable on exactly the edge where `opDone` is driven. It then checks that no verdict pulse appears and that the status word reads 0x00 rather than 0x02.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam logic [7:0] OP_BE   = 8'hD8;
  localparam logic [7:0] OP_CE   = 8'hC7;
  localparam logic [7:0] OP_DP   = 8'hB9;
  localparam logic [7:0] OP_RDP  = 8'hAB;

  // writable status bits: SRP (7) and protect field (4:2)
  localparam logic [7:0] SR_WRITABLE = 8'h9C;

  typedef enum logic [2:0] {
    K_WRSR = 3'd0,
    K_PP   = 3'd1,
    K_SE   = 3'd2,
    K_BE   = 3'd3,
    K_CE   = 3'd4
  } kind_e;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic startOp;
    logic finishOp;
    logic applySr;
    logic setLock;
  } strobe_t;

endpackage

// File: rtl/flash_guard_dp.sv
module flash_guard_dp
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int SECTOR_W = 12,
  parameter int BLOCK_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [7:0]        srData,
  input  logic [7:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              otpMode,
  output logic              wip,
  output logic              wel,
  output logic              srp,
  output logic              otpLock,
  output logic              addrProt,
  output logic [7:0]        statusReg
);

  localparam int FRAC_SHIFT = ADDR_W - 7;
  localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] SECTOR_MASK = (ONE_A << SECTOR_W) - ONE_A;
  localparam logic [ADDR_W-1:0] BLOCK_MASK  = (ONE_A << BLOCK_W) - ONE_A;

  logic       wipQ, welQ, lockQ;
  logic [7:0] nvQ;
  logic [2:0] bp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wipQ  <= 1'b0;
      welQ  <= 1'b0;
      lockQ <= 1'b0;
      nvQ   <= 8'h00;
    end else begin
      if (stb.startOp)       wipQ <= 1'b1;
      else if (stb.finishOp) wipQ <= 1'b0;
      if (stb.setWel)        welQ <= 1'b1;
      else if (stb.clrWel)   welQ <= 1'b0;
      if (stb.applySr)       nvQ  <= srData & SR_WRITABLE;
      if (stb.setLock)       lockQ <= 1'b1;
    end
  end

  assign bp = nvQ[4:2];

  // protected window is [protBase, top]; erase ranges are checked at their last byte
  logic [ADDR_W-1:0] lastAddr, protBase, protSize;
  always_comb begin
    unique case (cmdOp)
      OP_SE:   lastAddr = cmdAddr | SECTOR_MASK;
      OP_BE:   lastAddr = cmdAddr | BLOCK_MASK;
      default: lastAddr = cmdAddr;
    endcase
    protSize = ONE_A << (FRAC_SHIFT + int'(bp));
    protBase = (bp == 3'd7) ? '0 : ~(protSize - ONE_A);
    addrProt = (bp != 3'd0) && ((cmdOp == OP_CE) || (lastAddr >= protBase));
  end

  assign wip     = wipQ;
  assign wel     = welQ;
  assign srp     = nvQ[7];
  assign otpLock = lockQ;
  assign statusReg = {otpMode ? lockQ : nvQ[7], nvQ[6:2], nvQ[1:0] | {welQ, wipQ}};

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);

  assert_wel_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.startOp |-> welQ);

endmodule

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int CNT_W      = 16,
  parameter int PUW_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdOp,
  input  logic [CNT_W-1:0]  cmdBits,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  input  logic              wpN,
  input  logic              otpMode,
  input  logic              opDone,
  input  logic              wip,
  input  logic              wel,
  input  logic              srp,
  input  logic              otpLock,
  input  logic              addrProt,
  output strobe_t           stb,
  output logic [7:0]        srData,
  output logic              opStart,
  output logic [2:0]        opKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic              cmdAccept,
  output logic              cmdReject,
  output logic              deepPd,
  output logic              puwDone
);

  localparam int PUW_W = $clog2(PUW_CYCLES + 1);
  localparam logic [CNT_W-1:0] BYTE_MASK = CNT_W'(7);

  logic [PUW_W-1:0] puwCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        puwCnt <= '0;
    else if (!puwDone) puwCnt <= puwCnt + 1'b1;
  end
  assign puwDone = (puwCnt == PUW_W'(PUW_CYCLES));

  logic  dpQ, pendLockQ, accD, rejD, enterDp, exitDp;
  logic  isMod, isArray, isWrite, aligned, blocked;
  kind_e kindD, pendKindQ;

  always_comb begin
    unique case (cmdOp)
      OP_WRSR: kindD = K_WRSR;
      OP_PP:   kindD = K_PP;
      OP_SE:   kindD = K_SE;
      OP_BE:   kindD = K_BE;
      default: kindD = K_CE;
    endcase
    isArray = (cmdOp == OP_PP) || (cmdOp == OP_SE) || (cmdOp == OP_BE) || (cmdOp == OP_CE);
    isMod   = isArray || (cmdOp == OP_WRSR);
    isWrite = isMod || (cmdOp == OP_WREN);
    aligned = (cmdBits & BYTE_MASK) == '0;
    if (otpMode)      blocked = otpLock;
    else if (isArray) blocked = addrProt;
    else              blocked = srp && !wpN;
  end

  always_comb begin
    stb     = '0;
    accD    = 1'b0;
    rejD    = 1'b0;
    enterDp = 1'b0;
    exitDp  = 1'b0;
    if (wip && opDone) begin
      stb.finishOp = 1'b1;
      stb.clrWel   = 1'b1;
      if (pendKindQ == K_WRSR) begin
        stb.applySr = !pendLockQ;
        stb.setLock = pendLockQ;
      end
    end
    if (cmdValid) begin
      if (dpQ) begin
        if (cmdOp == OP_RDP) begin
          exitDp = 1'b1;
          accD   = 1'b1;
        end
      end else if (wip) begin
        accD = 1'b0;
      end else if (isWrite && !puwDone) begin
        rejD = 1'b1;
      end else if (isMod) begin
        if (!aligned || !wel) begin
          rejD = 1'b1;
        end else if (blocked) begin
          rejD       = 1'b1;
          stb.clrWel = 1'b1;
        end else begin
          accD        = 1'b1;
          stb.startOp = 1'b1;
        end
      end else begin
        unique case (cmdOp)
          OP_WREN: begin stb.setWel = 1'b1; accD = 1'b1; end
          OP_WRDI: begin stb.clrWel = 1'b1; accD = 1'b1; end
          OP_DP:   begin enterDp = 1'b1;    accD = 1'b1; end
          OP_RDSR, OP_RDP: accD = 1'b1;
          default: accD = 1'b0;
        endcase
      end
    end
  end

  kind_e opKindQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpQ       <= 1'b0;
      pendKindQ <= K_WRSR;
      pendLockQ <= 1'b0;
      srData    <= 8'h00;
      opStart   <= 1'b0;
      opKindQ   <= K_WRSR;
      opAddr    <= '0;
      cmdAccept <= 1'b0;
      cmdReject <= 1'b0;
    end else begin
      if (enterDp)     dpQ <= 1'b1;
      else if (exitDp) dpQ <= 1'b0;
      opStart   <= stb.startOp;
      cmdAccept <= accD;
      cmdReject <= rejD;
      if (stb.startOp) begin
        pendKindQ <= kindD;
        pendLockQ <= otpMode;
        srData    <= cmdData & SR_WRITABLE;
        opKindQ   <= kindD;
        opAddr    <= cmdAddr;
      end
    end
  end

  assign opKind = opKindQ;
  assign deepPd = dpQ;

  assert_puw_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setWel || stb.startOp) |-> puwDone);

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int CNT_W      = 16,
  parameter int PUW_CYCLES = 20,
  parameter int SECTOR_W   = 12,
  parameter int BLOCK_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdOp,
  input  logic [CNT_W-1:0]  cmdBits,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [7:0]        cmdData,
  input  logic              wpN,
  input  logic              otpMode,
  input  logic              opDone,
  output logic              opStart,
  output logic [2:0]        opKind,
  output logic [ADDR_W-1:0] opAddr,
  output logic [7:0]        statusReg,
  output logic              cmdAccept,
  output logic              cmdReject,
  output logic              deepPd,
  output logic              puwDone
);

  strobe_t    stb;
  logic [7:0] srData;
  logic       wip, wel, srp, otpLock, addrProt;

  flash_guard_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PUW_CYCLES(PUW_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBits(cmdBits),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .wpN(wpN), .otpMode(otpMode), .opDone(opDone),
    .wip(wip), .wel(wel), .srp(srp), .otpLock(otpLock), .addrProt(addrProt),
    .stb(stb), .srData(srData), .opStart(opStart), .opKind(opKind), .opAddr(opAddr),
    .cmdAccept(cmdAccept), .cmdReject(cmdReject), .deepPd(deepPd), .puwDone(puwDone)
  );

  flash_guard_dp #(.ADDR_W(ADDR_W), .SECTOR_W(SECTOR_W), .BLOCK_W(BLOCK_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .srData(srData), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .otpMode(otpMode), .wip(wip), .wel(wel), .srp(srp), .otpLock(otpLock),
    .addrProt(addrProt), .statusReg(statusReg)
  );

  assert_busy_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    opStart |-> statusReg[0]);

  assert_byte_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[0]) |-> ($past(cmdValid) && ($past(cmdBits) % 8) == 0));

  assert_wel_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusReg[0]) |-> !statusReg[1]);

  assert_dp_freeze_R7: assert property (@(posedge clk) disable iff (!rstN)
    deepPd |=> $stable(statusReg[6:0]));

endmodule

// File: tb/flash_guard_tb_top.sv
module flash_guard_tb_top;

  localparam int ADDR_W = 19;
  localparam int CNT_W  = 16;
  localparam int PUW    = 20;
  localparam int LAT    = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cmdValid = 1'b0;
  logic [7:0]        cmdOp = 8'h00;
  logic [CNT_W-1:0]  cmdBits = '0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [7:0]        cmdData = 8'h00;
  logic              wpN = 1'b1;
  logic              otpMode = 1'b0;
  logic              opDone = 1'b0;
  logic              opStart, cmdAccept, cmdReject, deepPd, puwDone;
  logic [2:0]        opKind;
  logic [ADDR_W-1:0] opAddr;
  logic [7:0]        statusReg;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int engCnt = 0;

  always #5 clk = ~clk;

  flash_guard #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PUW_CYCLES(PUW)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBits(cmdBits),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .wpN(wpN), .otpMode(otpMode), .opDone(opDone),
    .opStart(opStart), .opKind(opKind), .opAddr(opAddr), .statusReg(statusReg),
    .cmdAccept(cmdAccept), .cmdReject(cmdReject), .deepPd(deepPd), .puwDone(puwDone)
  );

  // array engine model: done pulse LAT negedges after a start is seen
  always @(negedge clk) begin
    opDone = 1'b0;
    if (engCnt > 0) begin
      engCnt = engCnt - 1;
      if (engCnt == 0) opDone = 1'b1;
    end
    if (opStart) engCnt = LAT;
  end

  typedef struct packed {
    logic [7:0]  op;
    logic [15:0] bits;
    logic [7:0]  data;
    logic [23:0] addr;
    logic        wp;
    logic        acc;
    logic        rej;
    logic [7:0]  st;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{8'h06, 16'd8,  8'h00, 24'h000000, 1'b1, 1'b1, 1'b0, 8'h02},
    '{8'h04, 16'd8,  8'h00, 24'h000000, 1'b1, 1'b1, 1'b0, 8'h00},
    '{8'h02, 16'd40, 8'h00, 24'h000100, 1'b1, 1'b0, 1'b1, 8'h00},
    '{8'h06, 16'd8,  8'h00, 24'h000000, 1'b1, 1'b1, 1'b0, 8'h02},
    '{8'h02, 16'd41, 8'h00, 24'h000100, 1'b1, 1'b0, 1'b1, 8'h02},
    '{8'h02, 16'd40, 8'h00, 24'h000100, 1'b1, 1'b1, 1'b0, 8'h00},
    '{8'h06, 16'd8,  8'h00, 24'h000000, 1'b1, 1'b1, 1'b0, 8'h02},
    '{8'h01, 16'd16, 8'h84, 24'h000000, 1'b1, 1'b1, 1'b0, 8'h84},
    '{8'h06, 16'd8,  8'h00, 24'h000000, 1'b1, 1'b1, 1'b0, 8'h86},
    '{8'h02, 16'd40, 8'h00, 24'h07E000, 1'b1, 1'b0, 1'b1, 8'h84},
    '{8'h06, 16'd8,  8'h00, 24'h000000, 1'b1, 1'b1, 1'b0, 8'h86},
    '{8'h20, 16'd32, 8'h00, 24'h07D000, 1'b1, 1'b1, 1'b0, 8'h84},
    '{8'h06, 16'd8,  8'h00, 24'h000000, 1'b1, 1'b1, 1'b0, 8'h86},
    '{8'hD8, 16'd32, 8'h00, 24'h070000, 1'b1, 1'b0, 1'b1, 8'h84},
    '{8'h06, 16'd8,  8'h00, 24'h000000, 1'b1, 1'b1, 1'b0, 8'h86},
    '{8'hC7, 16'd8,  8'h00, 24'h000000, 1'b1, 1'b0, 1'b1, 8'h84},
    '{8'h06, 16'd8,  8'h00, 24'h000000, 1'b0, 1'b1, 1'b0, 8'h86},
    '{8'h01, 16'd16, 8'h00, 24'h000000, 1'b0, 1'b0, 1'b1, 8'h84},
    '{8'h06, 16'd8,  8'h00, 24'h000000, 1'b1, 1'b1, 1'b0, 8'h86},
    '{8'h01, 16'd16, 8'h7C, 24'h000000, 1'b1, 1'b1, 1'b0, 8'h1C},
    '{8'h06, 16'd8,  8'h00, 24'h000000, 1'b1, 1'b1, 1'b0, 8'h1E},
    '{8'h02, 16'd40, 8'h00, 24'h000000, 1'b1, 1'b0, 1'b1, 8'h1C},
    '{8'h06, 16'd8,  8'h00, 24'h000000, 1'b1, 1'b1, 1'b0, 8'h1E},
    '{8'h01, 16'd16, 8'h00, 24'h000000, 1'b1, 1'b1, 1'b0, 8'h00},
    '{8'h05, 16'd8,  8'h00, 24'h000000, 1'b1, 1'b1, 1'b0, 8'h00},
    '{8'h9F, 16'd8,  8'h00, 24'h000000, 1'b1, 1'b0, 1'b0, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one event for one edge; returns at the following negedge
  task automatic issue(input logic [7:0] op, input int bits, input logic [7:0] data,
                       input logic [ADDR_W-1:0] addr);
    @(negedge clk);
    cmdOp = op; cmdBits = CNT_W'(bits); cmdData = data; cmdAddr = addr;
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 40 && statusReg[0]; i++) @(negedge clk);
  endtask

  task automatic verdict(input string req, input logic a, input logic r);
    chk(req, {30'd0, cmdAccept, cmdReject}, {30'd0, a, r});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 status", statusReg, 8'h00);
    chk("R12 flags", {deepPd, puwDone, cmdAccept, cmdReject}, 4'b0000);
    rstN = 1'b1;

    // R9 write enable before power-up wait expires
    issue(8'h06, 8, 8'h00, '0);
    verdict("R9 early wren", 1'b0, 1'b1);
    chk("R9 status", statusReg, 8'h00);
    repeat (PUW) @(negedge clk);
    chk("R9 puwDone", puwDone, 1'b1);

    // table walk: R2 R3 R4 R5 R6 R11 plus plain reads
    for (int v = 0; v < NV; v++) begin
      wpN = VEC[v].wp;
      issue(VEC[v].op, int'(VEC[v].bits), VEC[v].data, VEC[v].addr[ADDR_W-1:0]);
      verdict($sformatf("R2-table row %0d verdict", v), VEC[v].acc, VEC[v].rej);
      waitIdle();
      chk($sformatf("R6 R11 table row %0d status", v), statusReg, VEC[v].st);
    end
    wpN = 1'b1;

    // R1 busy, kind and address on a program
    issue(8'h06, 8, 8'h00, '0);
    issue(8'h02, 40, 8'h00, 19'h00200);
    chk("R1 start", {opStart, opKind}, {1'b1, 3'd1});
    chk("R1 addr", opAddr, 19'h00200);
    chk("R1 busy status", statusReg, 8'h03);
    // R10 instruction while busy is ignored
    issue(8'h04, 8, 8'h00, '0);
    verdict("R10 busy ignore", 1'b0, 1'b0);
    chk("R10 busy status", statusReg, 8'h03);
    waitIdle();
    chk("R1 R3 done status", statusReg, 8'h00);

    // R10 collision: write enable on the same edge as opDone
    issue(8'h06, 8, 8'h00, '0);
    issue(8'h20, 32, 8'h00, 19'h01000);
    chk("R1 erase kind", opKind, 3'd2);
    @(negedge clk);
    @(negedge clk);
    issue(8'h06, 8, 8'h00, '0);
    verdict("R10 collision verdict", 1'b0, 1'b0);
    chk("R10 collision status", statusReg, 8'h00);

    // R7 deep power-down
    issue(8'h06, 8, 8'h00, '0);
    issue(8'hB9, 8, 8'h00, '0);
    chk("R7 enter", deepPd, 1'b1);
    issue(8'h04, 8, 8'h00, '0);
    verdict("R7 ignored verdict", 1'b0, 1'b0);
    chk("R7 ignored status", statusReg, 8'h02);
    issue(8'hAB, 8, 8'h00, '0);
    verdict("R7 release verdict", 1'b1, 1'b0);
    chk("R7 release", {deepPd, statusReg}, {1'b0, 8'h02});
    issue(8'h04, 8, 8'h00, '0);

    // R8 OTP lock
    otpMode = 1'b1;
    issue(8'h06, 8, 8'h00, '0);
    issue(8'h01, 16, 8'h1C, '0);
    verdict("R8 lock write", 1'b1, 1'b0);
    waitIdle();
    chk("R8 locked status", statusReg, 8'h80);
    issue(8'h06, 8, 8'h00, '0);
    issue(8'h02, 40, 8'h00, 19'h00000);
    verdict("R8 locked program", 1'b0, 1'b1);
    chk("R8 wel cleared", statusReg, 8'h80);
    otpMode = 1'b0;
    @(negedge clk);
    chk("R8 R11 normal view", statusReg, 8'h00);
    otpMode = 1'b1;
    @(negedge clk);
    chk("R8 sticky", statusReg, 8'h80);
    issue(8'h06, 8, 8'h00, '0);
    issue(8'h01, 16, 8'h00, '0);
    verdict("R8 relock", 1'b0, 1'b1);
    otpMode = 1'b0;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule